// File: doc/BRIEF.md
# Recursive Vertically-and-Crosswise Unsigned Multiplier

This block multiplies two unsigned operands and returns the full-width product with no clock: it is pure combinational logic. It follows the vertically-and-crosswise rule. Each product column collects the operand digit products whose positions add up to that column. The rule is applied recursively. A 2x2 core cell produces a 4-bit product. Four such results form a 4x4 product, four of those form an 8x8 product, and so on up to the configured width (16 by default).

At each level, each operand is split into a high and a low half. The four half-width products (low-low, low-high, high-low, high-high) are formed in parallel. The low half of the low-low product becomes the low bits of the result directly. The two crosswise products are summed. That sum is added to the upper half of the low-low product, and the result is then added to the high-high product shifted left by half the operand width. Every adder is a ripple chain built from reversible-style cells. The half adder is a three-line gate with one constant line. The full adder is two exclusive-or stages that pass one operand through, plus a 2:1 multiplexer that selects the carry.

Top module: `urdhva_mul`

## Requirements
- R1: `prod_out` equals the unsigned product `a_in * b_in` in all 2*WIDTH bits, for every operand pair.
- R2: The product follows the inputs with no clock. A new operand pair gives the new product once the logic settles, with no clock edge in between.
- R3: Bit 0 of `prod_out` equals `a_in[0] & b_in[0]`.
- R4: If either operand is zero, `prod_out` is zero.
- R5: If one operand is 1, `prod_out` equals the other operand, zero-extended.
- R6: The all-ones operands give the largest product, 0xFFFE0001 at WIDTH=16, and no bit is lost.
- R7: If both operands are below 2^(WIDTH/2), the upper WIDTH bits of `prod_out` are zero.
- R8: WIDTH must be a power of two of at least 2. At WIDTH=4, the product is exact for all 256 operand pairs.
- R9: Swapping the operands leaves `prod_out` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_in | input | WIDTH | Multiplicand, unsigned |
| b_in | input | WIDTH | Multiplier, unsigned |
| prod_out | output | 2*WIDTH | Full unsigned product |

## Verification
A 4-bit instance is swept over all 256 operand pairs. This catches any wrong wiring in the 2x2 core or in one level of half-splitting and merging. At 16 bits, pseudo-random pairs exercise the three merging levels together. The operands are also checked in swapped order, which separates errors in the two crosswise paths, since those paths would otherwise mask each other. Corner operands (zero, one, all-ones, a lone top bit, alternating bit patterns) are aimed at the longest carry chains and at the joints between the halves. Small operands confirm that no stray carry reaches the upper half.

// File: rtl/urdhva_pkg.sv
package urdhva_pkg;
  // A width is legal when it is a power of two and at least 2.
  function automatic bit width_ok(input int w);
    return (w >= 2) && ((w & (w - 1)) == 0);
  endfunction
endpackage

// File: rtl/rev_half_add.sv
// Half adder as a three-line reversible gate with its third line held at 0.
// Lines: pass = x, s = x ^ y, c = (x & y) ^ k.
module rev_half_add (
  input  logic x,
  input  logic y,
  output logic s,
  output logic c
);
  logic k_const;
  assign k_const = 1'b0;
  assign s = x ^ y;
  assign c = (x & y) ^ k_const;
endmodule

// File: rtl/rev_full_add.sv
// Full adder from two exclusive-or pass-through stages and a carry multiplexer.
module rev_full_add (
  input  logic x,
  input  logic y,
  input  logic ci,
  output logic s,
  output logic co
);
  logic q;
  assign q  = x ^ y;         // first stage: keeps x, yields x^y
  assign s  = q ^ ci;        // second stage: keeps q, yields the sum
  assign co = q ? ci : x;    // propagate takes carry-in, else generate/kill from x
endmodule

// File: rtl/rc_adder.sv
// Ripple chain of reversible full adders.
module rc_adder #(
  parameter int W = 8
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  input  logic         cin,
  output logic [W-1:0] s,
  output logic         cout
);
  logic [W:0] cy;
  assign cy[0] = cin;
  for (genvar i = 0; i < W; i++) begin : g_bit
    rev_full_add u_fa (.x(x[i]), .y(y[i]), .ci(cy[i]), .s(s[i]), .co(cy[i+1]));
  end
  assign cout = cy[W];
endmodule

// File: rtl/urdhva_base2.sv
// 2x2 core: p0 direct, two half adders build the remaining bits.
module urdhva_base2 (
  input  logic [1:0] a,
  input  logic [1:0] b,
  output logic [3:0] p
);
  logic c1;
  assign p[0] = a[0] & b[0];
  rev_half_add u_col1 (.x(a[1] & b[0]), .y(a[0] & b[1]), .s(p[1]), .c(c1));
  rev_half_add u_col2 (.x(a[1] & b[1]), .y(c1),          .s(p[2]), .c(p[3]));
endmodule

// File: rtl/urdhva_node.sv
// Recursive NxN unit: four N/2 products merged by ripple adders.
module urdhva_node #(
  parameter int N = 16
) (
  input  logic [N-1:0]   a,
  input  logic [N-1:0]   b,
  output logic [2*N-1:0] p
);
  if (N == 2) begin : g_base
    urdhva_base2 u_core (.a(a), .b(b), .p(p));
  end else begin : g_split
    localparam int H = N / 2;
    logic [N-1:0] ll, lh, hl, hh;

    urdhva_node #(.N(H)) u_ll (.a(a[H-1:0]), .b(b[H-1:0]), .p(ll));
    urdhva_node #(.N(H)) u_lh (.a(a[H-1:0]), .b(b[N-1:H]), .p(lh));
    urdhva_node #(.N(H)) u_hl (.a(a[N-1:H]), .b(b[H-1:0]), .p(hl));
    urdhva_node #(.N(H)) u_hh (.a(a[N-1:H]), .b(b[N-1:H]), .p(hh));

    // crosswise sum
    logic [N-1:0] cross_s;
    logic         cross_c;
    rc_adder #(.W(N)) u_cross (
      .x(lh), .y(hl), .cin(1'b0), .s(cross_s), .cout(cross_c));

    // add upper half of low-low product
    logic [N:0] mid_s;
    logic       unused_mid_c;
    rc_adder #(.W(N+1)) u_mid (
      .x({cross_c, cross_s}), .y({{(H+1){1'b0}}, ll[N-1:H]}),
      .cin(1'b0), .s(mid_s), .cout(unused_mid_c));

    // add high-high product shifted by H
    logic [3*H-1:0] up_s;
    logic           unused_up_c;
    rc_adder #(.W(3*H)) u_up (
      .x({{(H-1){1'b0}}, mid_s}), .y({hh, {H{1'b0}}}),
      .cin(1'b0), .s(up_s), .cout(unused_up_c));

    assign p = {up_s, ll[H-1:0]};
  end
endmodule

// File: rtl/urdhva_mul.sv
module urdhva_mul #(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0]   a_in,
  input  logic [WIDTH-1:0]   b_in,
  output logic [2*WIDTH-1:0] prod_out
);
  if (!urdhva_pkg::width_ok(WIDTH)) begin : g_bad_width
    $error("WIDTH must be a power of two, at least 2 (R8)");
  end
  urdhva_node #(.N(WIDTH)) u_tree (.a(a_in), .b(b_in), .p(prod_out));
endmodule

// File: rtl/urdhva_mul_chk.sv
module urdhva_mul_chk #(
  parameter int WIDTH = 16
) (
  input logic [WIDTH-1:0]   a_in,
  input logic [WIDTH-1:0]   b_in,
  input logic [2*WIDTH-1:0] prod_out
);
  localparam int HW = WIDTH / 2;
  logic [2*WIDTH-1:0] ref_p;
  assign ref_p = {{WIDTH{1'b0}}, a_in} * {{WIDTH{1'b0}}, b_in};

  always_comb begin
    assert_exact_R1: assert (prod_out == ref_p)
      else $error("product mismatch");
    assert_lsb_R3: assert (prod_out[0] == (a_in[0] & b_in[0]))
      else $error("bit 0 mismatch");
    if (a_in == '0 || b_in == '0)
      assert_zero_R4: assert (prod_out == '0) else $error("zero operand");
    if (a_in == WIDTH'(1))
      assert_unit_R5: assert (prod_out == {{WIDTH{1'b0}}, b_in}) else $error("unit operand");
    if (a_in[WIDTH-1:HW] == '0 && b_in[WIDTH-1:HW] == '0)
      assert_small_R7: assert (prod_out[2*WIDTH-1:WIDTH] == '0) else $error("upper half set");
  end
endmodule

bind urdhva_mul urdhva_mul_chk #(.WIDTH(WIDTH)) u_chk (
  .a_in(a_in), .b_in(b_in), .prod_out(prod_out));

// File: tb/urdhva_mul_test.sv
`timescale 1ns/1ps
module urdhva_mul_test;
  logic clk;
  initial clk = 1'b0;
  always #10 clk = ~clk;   // 50 MHz

  logic [15:0] a, b;
  logic [31:0] p;
  logic [3:0]  sa, sb;
  logic [7:0]  sp;
  int errors = 0;
  int checks = 0;
  bit done = 0;

  urdhva_mul #(.WIDTH(16)) uut     (.a_in(a),  .b_in(b),  .prod_out(p));
  urdhva_mul #(.WIDTH(4))  uut_small (.a_in(sa), .b_in(sb), .prod_out(sp));

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic apply(input logic [15:0] x, input logic [15:0] y);
    @(negedge clk);
    a = x; b = y;
    #2;
  endtask

  task automatic full_check(input logic [15:0] x, input logic [15:0] y, input string tag);
    logic [31:0] e;
    e = 32'(x) * 32'(y);
    apply(x, y);
    check(p, e, tag);
    apply(y, x);
    check(p, e, "R9 swapped");
  endtask

  initial begin
    a = '0; b = '0; sa = '0; sb = '0;
    #5;
    check(p, 32'h0, "R4 initial zero operands");

    // R2: two operand changes with no clock edge in between
    a = 16'd300; b = 16'd7; #1;
    check(p, 32'd2100, "R2 no clock needed");
    a = 16'd12; #1;
    check(p, 32'd84, "R2 follows input change");

    // R8: exhaustive 4x4
    for (int i = 0; i < 16; i++) begin
      for (int j = 0; j < 16; j++) begin
        sa = 4'(i); sb = 4'(j); #1;
        check(32'(sp), 32'(i * j), "R8 4x4 exhaustive");
      end
    end

    full_check(16'hFFFF, 16'hFFFF, "R6 all ones");
    check(p, 32'hFFFE0001, "R6 max product constant");
    full_check(16'h0000, 16'hBEEF, "R4 zero operand");
    check(p, 32'h0, "R4 zero product");
    full_check(16'h0001, 16'hCAFE, "R5 unit operand");
    check(p, 32'h0000CAFE, "R5 passes other operand");
    full_check(16'h8000, 16'h8000, "R1 top bits");
    check(p, 32'h40000000, "R1 top bit square");
    full_check(16'hAAAA, 16'h5555, "R1 alternating");
    full_check(16'h00FF, 16'h00FF, "R7 small operands");
    check({16'h0, p[31:16]}, 32'h0, "R7 upper half zero");
    full_check(16'h00FF, 16'hFF00, "R1 half boundary");

    apply(16'h0003, 16'h0005);
    check({31'h0, p[0]}, 32'h1, "R3 bit0 odd*odd");
    apply(16'h0003, 16'h0006);
    check({31'h0, p[0]}, 32'h0, "R3 bit0 odd*even");

    for (int k = 0; k < 400; k++) begin
      logic [15:0] x, y;
      x = 16'($urandom); y = 16'($urandom);
      full_check(x, y, "R1 random");
    end
    done = 1;
  end

  initial begin
    for (int t = 0; t < 100000 && !done; t++) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule